// File: doc/BRIEF.md
# Configurable External Trigger Detector

This block turns an asynchronous external event into a start request for an A/D conversion sequencer. The event can come from any one of several dedicated trigger pins or from the digital input path of one of the analog channels. A source select field picks the line. The chosen line passes through a synchroniser. The block then applies one of four sensitivities, chosen by a level/edge bit and a polarity bit, and drives a single request line towards the sequencer.

In edge mode, each qualifying transition gives a one-cycle request pulse. In level mode, the request stays high for as long as the active level persists and the sequencer reports that it is idle. A global enable gates all triggering. While the converter runs in stop mode, every trigger is ignored. When the source select or the polarity changes, the detector ignores its input until the synchroniser holds only the new source. A reconfiguration therefore never looks like an edge.

Top module: `exttrig_detect`

## Requirements
- R1: With level_mode_i=0 and polarity_i=0 (sensitivity code 2'b00), a falling transition on the selected line produces a request, and a rising transition produces none.
- R2: With level_mode_i=0 and polarity_i=1 (code 2'b01), a rising transition on the selected line produces a request, and a falling transition produces none.
- R3: With level_mode_i=1 and polarity_i=0 (code 2'b10), a high level on the selected line produces a request, and a low level produces none.
- R4: With level_mode_i=1 and polarity_i=1 (code 2'b11), a low level on the selected line produces a request, and a high level produces none.
- R5: While trig_en_i is 0, start_req_o stays 0 one cycle later, whatever the trigger lines do.
- R6: Select values 0 to NUM_PINS-1 pick trig_pin_i[sel], and values NUM_PINS to NUM_PINS+NUM_CHAN-1 pick chan_din_i[sel-NUM_PINS]. Any larger select value never produces a request, and lines that are not selected have no effect.
- R7: While stop_conv_i is 1, start_req_o is 0 one cycle later.
- R8: A qualifying change on the selected line, applied between clock edges, first shows on start_req_o after the third following rising clock edge (two synchroniser stages plus the output register).
- R9: In edge mode, each qualifying transition gives exactly one cycle of start_req_o.
- R10: In level mode, start_req_o stays high for as long as the active level persists. It drops one cycle after seq_busy_i rises.
- R11: After any change of src_sel_i or polarity_i, start_req_o is 0 for the next SYNC_STAGES+1 cycles. The change alone never creates an edge request.
- R12: While rst_n is 0, start_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| trig_pin_i | input | NUM_PINS | Dedicated trigger pins (asynchronous) |
| chan_din_i | input | NUM_CHAN | Digital input path of the analog channels (asynchronous) |
| trig_en_i | input | 1 | Trigger enable |
| level_mode_i | input | 1 | 0 edge sensitive, 1 level sensitive |
| polarity_i | input | 1 | Polarity bit, see R1 to R4 |
| src_sel_i | input | SEL_W | Trigger source select |
| stop_conv_i | input | 1 | Converter is running in stop mode |
| seq_busy_i | input | 1 | Sequencer busy; suppresses level requests |
| start_req_o | output | 1 | Start request to the sequencer |

## Verification
The hardest case to reach is a reconfiguration while the old and new sources sit at different levels. This is the case where a careless detector would emit a false edge. The stimulus sweeps every source under all four sensitivities. Each step parks the lines at the inactive level, changes the select or polarity so that the stale synchroniser contents differ from the new source, and then watches every cycle of the settling window. Out-of-range selects are driven in the low-level mode, where a constant-zero line would otherwise look active.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // Sensitivity encoding: {level_mode, polarity}
  typedef enum logic [1:0] {
    SENS_FALL = 2'b00,
    SENS_RISE = 2'b01,
    SENS_HIGH = 2'b10,
    SENS_LOW  = 2'b11
  } sens_e;
endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int NUM_PINS = 4,
  parameter int NUM_CHAN = 8,
  parameter int SEL_W    = 4
) (
  input  logic [NUM_PINS-1:0] pins,
  input  logic [NUM_CHAN-1:0] chans,
  input  logic [SEL_W-1:0]    sel,
  output logic                line,
  output logic                sel_ok
);
  localparam int NSRC = NUM_PINS + NUM_CHAN;

  logic [NSRC-1:0] all_src;
  assign all_src = {chans, pins};

  always_comb begin
    line   = 1'b0;
    sel_ok = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (int'(sel) == i) begin
        line   = all_src[i];
        sel_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/trig_detect.sv
module trig_detect
  import trig_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int SETTLE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s,
  input  logic [SEL_W-1:0] sel,
  input  logic             sel_ok,
  input  sens_e            sens,
  input  logic             en,
  input  logic             stop,
  input  logic             busy,
  output logic             req
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic             hist_q;
  logic [SEL_W-1:0] sel_q;
  logic             pol_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             pol, lvl, cfg_chg, settled, edge_hit, lvl_hit;

  assign pol = sens[0];
  assign lvl = sens[1];

  always_comb begin
    cfg_chg  = (sel != sel_q) || (pol != pol_q);
    settled  = (cnt_q == '0) && !cfg_chg;
    edge_hit = (s != hist_q) && (s == pol);
    lvl_hit  = (s == !pol) && !busy;
    if (cfg_chg)            cnt_d = CNT_W'(SETTLE);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
    req_d = en && !stop && sel_ok && settled && (lvl ? lvl_hit : edge_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      sel_q  <= '0;
      pol_q  <= 1'b0;
      cnt_q  <= CNT_W'(SETTLE);
      req_q  <= 1'b0;
    end else begin
      hist_q <= s;
      sel_q  <= sel;
      pol_q  <= pol;
      cnt_q  <= cnt_d;
      req_q  <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/exttrig_detect.sv
module exttrig_detect
  import trig_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int NUM_CHAN    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(NUM_PINS + NUM_CHAN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] trig_pin_i,
  input  logic [NUM_CHAN-1:0] chan_din_i,
  input  logic                trig_en_i,
  input  logic                level_mode_i,
  input  logic                polarity_i,
  input  logic [SEL_W-1:0]    src_sel_i,
  input  logic                stop_conv_i,
  input  logic                seq_busy_i,
  output logic                start_req_o
);
  localparam int SETTLE = SYNC_STAGES + 1;

  logic  raw_line, sel_ok, sync_line;
  sens_e sens;

  assign sens = sens_e'({level_mode_i, polarity_i});

  trig_src_mux #(.NUM_PINS(NUM_PINS), .NUM_CHAN(NUM_CHAN), .SEL_W(SEL_W)) u_mux (
    .pins(trig_pin_i), .chans(chan_din_i), .sel(src_sel_i),
    .line(raw_line), .sel_ok(sel_ok)
  );

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_line), .q(sync_line)
  );

  trig_detect #(.SEL_W(SEL_W), .SETTLE(SETTLE)) u_det (
    .clk(clk), .rst_n(rst_n), .s(sync_line), .sel(src_sel_i), .sel_ok(sel_ok),
    .sens(sens), .en(trig_en_i), .stop(stop_conv_i), .busy(seq_busy_i),
    .req(start_req_o)
  );
endmodule

// File: rtl/exttrig_detect_chk.sv
module exttrig_detect_chk #(
  parameter int SEL_W = 4,
  parameter int NSRC  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_en_i,
  input logic             level_mode_i,
  input logic             polarity_i,
  input logic [SEL_W-1:0] src_sel_i,
  input logic             stop_conv_i,
  input logic             seq_busy_i,
  input logic             start_req_o
);
  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en_i |=> !start_req_o);

  // R7
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_conv_i |=> !start_req_o);

  // R9
  edge_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req_o && !level_mode_i) |=> (!start_req_o || level_mode_i));

  // R10
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy_i && level_mode_i) |=> !start_req_o);

  // R11
  sel_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i != $past(src_sel_i)) |=> !start_req_o);

  // R11
  pol_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (polarity_i != $past(polarity_i)) |=> !start_req_o);

  // R6
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(src_sel_i) >= NSRC) |=> !start_req_o);

  // R12
  always @(posedge clk) begin
    if (!rst_n) reset_low_chk: assert (!start_req_o);
  end
endmodule

bind exttrig_detect exttrig_detect_chk #(.SEL_W(SEL_W), .NSRC(NUM_PINS + NUM_CHAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_en_i(trig_en_i), .level_mode_i(level_mode_i),
  .polarity_i(polarity_i), .src_sel_i(src_sel_i), .stop_conv_i(stop_conv_i),
  .seq_busy_i(seq_busy_i), .start_req_o(start_req_o)
);

// File: tb/tb_exttrig_detect.sv
module tb_exttrig_detect;
  localparam int NP = 4, NC = 8, NS = NP + NC, SW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0] pins;
  logic [NC-1:0] chans;
  logic en, lvl, pol, stop, busy, req;
  logic [SW-1:0] sel;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  exttrig_detect #(.NUM_PINS(NP), .NUM_CHAN(NC)) dut (
    .clk(clk), .rst_n(rst_n), .trig_pin_i(pins), .chan_din_i(chans),
    .trig_en_i(en), .level_mode_i(lvl), .polarity_i(pol), .src_sel_i(sel),
    .stop_conv_i(stop), .seq_busy_i(busy), .start_req_o(req)
  );

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string r, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: start_req=%0b expected %0b at %0t", r, act, exp, $time);
    end
  endtask

  task automatic set_line(int idx, logic v);
    if (idx < NP) pins[idx] = v;
    else if (idx < NS) chans[idx-NP] = v;
  endtask

  task automatic set_all(logic v);
    pins = {NP{v}}; chans = {NC{v}};
  endtask

  function automatic string mode_tag(logic l, logic p);
    return l ? (p ? "R4" : "R3") : (p ? "R2" : "R1");
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; lvl = 1'b0; pol = 1'b0; stop = 1'b0; busy = 1'b0;
    sel = '0; set_all(1'b1);
    tick(3);
    chk("R12", req, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    tick(6);
    chk("R12", req, 1'b0);

    // Full sweep: every source under every sensitivity
    for (int s = 0; s < NS; s++) begin
      for (int m = 0; m < 4; m++) begin
        logic l, p, base, act;
        string t;
        int other;
        l = m[1]; p = m[0]; t = mode_tag(l, p);
        base = l ? p : !p;
        act  = !base;
        other = (s + 1) % NS;
        // park inactive, then reconfigure with a stale synchroniser
        set_all(act);
        tick(4);
        set_all(base);
        lvl = l; pol = p; sel = SW'(s);
        for (int k = 0; k < 6; k++) begin tick(); chk("R11", req, 1'b0); end
        // qualifying change on the selected line
        set_line(s, act);
        tick(2); chk("R8", req, 1'b0);
        tick();  chk(t, req, 1'b1);
        tick();
        if (!l) chk("R9", req, 1'b0);
        else begin
          chk("R10", req, 1'b1);
          busy = 1'b1; tick(); chk("R10", req, 1'b0);
          busy = 1'b0; tick(); chk("R10", req, 1'b1);
        end
        // back to inactive: no request
        set_line(s, base);
        for (int k = 0; k < 4; k++) tick();
        chk(t, req, 1'b0);
        // another line must not trigger
        set_line(other, act);
        for (int k = 0; k < 5; k++) begin tick(); chk("R6", req, 1'b0); end
        set_line(other, base);
        tick(4);
      end
    end

    // R5: enable low, rising edge mode
    lvl = 1'b0; pol = 1'b1; sel = 4'd2; set_all(1'b0); tick(6);
    en = 1'b0; set_line(2, 1'b1);
    for (int k = 0; k < 5; k++) begin tick(); chk("R5", req, 1'b0); end
    set_line(2, 1'b0); tick(4); en = 1'b1;

    // R7: stop mode, high-level mode
    lvl = 1'b1; pol = 1'b0; sel = 4'd7; set_all(1'b0); tick(6);
    stop = 1'b1; set_line(7, 1'b1);
    for (int k = 0; k < 5; k++) begin tick(); chk("R7", req, 1'b0); end
    stop = 1'b0; tick(); chk("R7", req, 1'b1);
    set_line(7, 1'b0); tick(4);

    // R6: out-of-range selects in low-level mode
    lvl = 1'b1; pol = 1'b1; set_all(1'b0);
    for (int v = NS; v < 16; v++) begin
      sel = SW'(v);
      for (int k = 0; k < 6; k++) begin tick(); chk("R6", req, 1'b0); end
    end

    // R11: polarity flip with line high in edge mode gives no edge
    lvl = 1'b0; pol = 1'b0; sel = 4'd5; set_all(1'b1); tick(6);
    pol = 1'b1;
    for (int k = 0; k < 6; k++) begin tick(); chk("R11", req, 1'b0); end

    finish_run();
  end
endmodule